// File: doc/BRIEF.md
# Indexed Performance Counter Bank

This block holds a set of wide event counters that software programs and reads through a narrow synchronous register bus. Every counter watches one of several event inputs, chosen by a per-counter condition number; condition number zero is reserved and never counts, which is the only way to stop an individual counter. A single run bit in the control register starts and stops the whole bank at once.

Software first writes the selection register to point at one counter; the condition, the count-load and the snapshot accesses that follow all act on that counter alone. A counter is wider than the bus, so a snapshot strobe copies the selected counter into two read-only capture registers. The two halves can then be read at leisure and always belong to the same instant. Two read-only build words describe the bank: the number of counters, the width code, and the number of event inputs.

Top module: `perf_counter_bank`

## Requirements
- R1: After synchronous reset every counter, every condition number, the run bit, the upper control field, the selection register, both capture registers and rd_data are zero.
- R2: Address 1 is the selection register; a write stores wr_data[7:0], and a read returns that value in bits 7:0 with zeros above.
- R3: Address 2 reads and writes the 8-bit condition number of the selected counter. Condition 0, and any number at or above NUM_COND, never counts, so such a counter holds its value.
- R4: A counter adds exactly one on each clock edge where the run bit is 1 and event input cond_in[n] is 1, with n its nonzero condition number. It wraps to zero after 2^(32+16*WIDTH_SEL)-1.
- R5: Address 0 is control: bit 0 is the run bit for all counters, and bits 31:16 are stored and read back as written. Bits 15:1 read as 0. While the run bit is 0 no counter changes except by a load.
- R6: Writing control with bit 1 set copies the selected counter, as it stood before that edge, into capture-low (address 5, counter bits 31:0) and capture-high (address 6, counter bits above 31, zero-extended). Later counting leaves both capture registers unchanged until the next strobe.
- R7: A write to address 3 replaces bits 31:0 of the selected counter; a write to address 4 replaces the bits above 31 from wr_data. A load takes priority over counting on that edge. Reading addresses 3 and 4 returns the live counter halves.
- R8: Address 7 reads {20'b0, WIDTH_SEL[3:0], NUM_CTR[7:0]}, and address 8 reads NUM_COND in bits 7:0. Writes to them have no effect.
- R9: With a selection value at or above NUM_CTR, writes to addresses 2, 3 and 4 and snapshot strobes change nothing, and reads of addresses 2, 3 and 4 return 0.
- R10: rd_data is registered: after each clock edge it holds the register selected by addr before that edge. Addresses 9 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_in | input | NUM_COND | Event inputs; bit 0 is unused |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |

## Verification
Event inputs are driven with all ones, all zeros and random patterns every cycle. These separate a counter that follows its own condition from one that follows a neighbour or counts unconditionally. Condition numbers are written in and out of range and switched while the bank runs, and the run bit is toggled during loads and captures. This shows whether stopping comes from the run bit, from condition zero, or from load priority. A counter loaded just below its maximum shows the carry across the 32-bit boundary and the wrap. Out-of-range selections mixed into random traffic show whether a stray access leaks into a real counter.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  typedef enum logic [3:0] {
    REG_CTRL      = 4'd0,
    REG_SELECT    = 4'd1,
    REG_COND      = 4'd2,
    REG_LOAD_LO   = 4'd3,
    REG_LOAD_HI   = 4'd4,
    REG_CAP_LO    = 4'd5,
    REG_CAP_HI    = 4'd6,
    REG_INFO_CTR  = 4'd7,
    REG_INFO_COND = 4'd8
  } pcb_reg_e;

  localparam int unsigned BUS_W  = 32;
  localparam int unsigned COND_W = 8;
endpackage

// File: rtl/pcb_counter.sv
module pcb_counter #(
  parameter int unsigned CW       = 48,
  parameter int unsigned NUM_COND = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       run_en,
  input  logic [NUM_COND-1:0]        cond_in,
  input  logic                       cfg_we,
  input  logic                       lo_we,
  input  logic                       hi_we,
  input  logic [pcb_pkg::BUS_W-1:0]  wr_data,
  output logic [pcb_pkg::COND_W-1:0] cfg_q,
  output logic [CW-1:0]              cnt_q
);
  localparam int unsigned HW = CW - 32;

  logic hit;

  always_comb begin
    hit = 1'b0;
    for (int c = 1; c < int'(NUM_COND); c++) begin
      if (cfg_q == pcb_pkg::COND_W'(c)) hit = cond_in[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else begin
      if (cfg_we) cfg_q <= wr_data[pcb_pkg::COND_W-1:0];
      if (lo_we)                cnt_q[31:0]    <= wr_data;
      else if (hi_we)           cnt_q[CW-1:32] <= wr_data[HW-1:0];
      else if (run_en && hit)   cnt_q          <= cnt_q + 1'b1;
    end
  end

  // R3: condition zero never counts
  a_r3_never_holds: assert property (@(posedge clk) disable iff (rst)
    (cfg_q == '0 && !lo_we && !hi_we) |=> $stable(cnt_q));
  // R5: bank stopped, counter frozen
  a_r5_stopped_holds: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !lo_we && !hi_we) |=> $stable(cnt_q));
  // R4: a live event adds exactly one
  a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
    (run_en && cfg_q != '0 && cfg_q < pcb_pkg::COND_W'(NUM_COND) &&
     cond_in[cfg_q[$clog2(NUM_COND)-1:0]] && !lo_we && !hi_we)
    |=> cnt_q == CW'($past(cnt_q) + 1'b1));
  // R7: low load lands intact
  a_r7_low_load: assert property (@(posedge clk) disable iff (rst)
    lo_we |=> cnt_q[31:0] == $past(wr_data));
endmodule

// File: rtl/pcb_capture.sv
module pcb_capture #(
  parameter int unsigned CW = 48
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      take,
  input  logic [CW-1:0]             src,
  output logic [pcb_pkg::BUS_W-1:0] lo_q,
  output logic [pcb_pkg::BUS_W-1:0] hi_q
);
  localparam int unsigned HW = CW - 32;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (take) begin
      lo_q <= src[31:0];
      hi_q <= {{(32-HW){1'b0}}, src[CW-1:32]};
    end
  end

  // R6: capture holds the pre-edge counter value
  a_r6_capture_value: assert property (@(posedge clk) disable iff (rst)
    take |=> {hi_q[HW-1:0], lo_q} == $past(src));
  // R6: capture is stable without a strobe
  a_r6_capture_stable: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(lo_q) && $stable(hi_q));
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank #(
  parameter int unsigned NUM_CTR   = 4,
  parameter int unsigned WIDTH_SEL = 1,
  parameter int unsigned NUM_COND  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_COND-1:0] cond_in,
  input  logic [3:0]          addr,
  input  logic                wr_en,
  input  logic [31:0]         wr_data,
  output logic [31:0]         rd_data
);
  import pcb_pkg::*;

  localparam int unsigned CW = 32 + 16 * WIDTH_SEL;
  localparam int unsigned HW = CW - 32;

  logic                run_q;
  logic [15:0]         ctrl_hi_q;
  logic [COND_W-1:0]   sel_q;
  logic                sel_ok;
  logic [COND_W-1:0]   cfg_q [NUM_CTR];
  logic [CW-1:0]       cnt_q [NUM_CTR];
  logic [COND_W-1:0]   sel_cfg;
  logic [CW-1:0]       sel_cnt;
  logic                take;
  logic [31:0]         cap_lo, cap_hi;
  logic [31:0]         rd_next;

  assign sel_ok = sel_q < COND_W'(NUM_CTR);
  assign take   = wr_en && addr == REG_CTRL && wr_data[1] && sel_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      ctrl_hi_q <= '0;
      sel_q     <= '0;
    end else if (wr_en) begin
      if (addr == REG_CTRL) begin
        run_q     <= wr_data[0];
        ctrl_hi_q <= wr_data[31:16];
      end
      if (addr == REG_SELECT) sel_q <= wr_data[COND_W-1:0];
    end
  end

  for (genvar i = 0; i < int'(NUM_CTR); i++) begin : g_ctr
    logic hit_me;
    assign hit_me = wr_en && sel_q == COND_W'(i);
    pcb_counter #(.CW(CW), .NUM_COND(NUM_COND)) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .run_en  (run_q),
      .cond_in (cond_in),
      .cfg_we  (hit_me && addr == REG_COND),
      .lo_we   (hit_me && addr == REG_LOAD_LO),
      .hi_we   (hit_me && addr == REG_LOAD_HI),
      .wr_data (wr_data),
      .cfg_q   (cfg_q[i]),
      .cnt_q   (cnt_q[i])
    );
  end

  always_comb begin
    sel_cfg = '0;
    sel_cnt = '0;
    for (int i = 0; i < int'(NUM_CTR); i++) begin
      if (sel_q == COND_W'(i)) begin
        sel_cfg = cfg_q[i];
        sel_cnt = cnt_q[i];
      end
    end
  end

  pcb_capture #(.CW(CW)) u_cap (
    .clk  (clk),
    .rst  (rst),
    .take (take),
    .src  (sel_cnt),
    .lo_q (cap_lo),
    .hi_q (cap_hi)
  );

  always_comb begin
    case (addr)
      REG_CTRL:      rd_next = {ctrl_hi_q, 15'b0, run_q};
      REG_SELECT:    rd_next = {24'b0, sel_q};
      REG_COND:      rd_next = {24'b0, sel_cfg};
      REG_LOAD_LO:   rd_next = sel_cnt[31:0];
      REG_LOAD_HI:   rd_next = {{(32-HW){1'b0}}, sel_cnt[CW-1:32]};
      REG_CAP_LO:    rd_next = cap_lo;
      REG_CAP_HI:    rd_next = cap_hi;
      REG_INFO_CTR:  rd_next = {20'b0, 4'(WIDTH_SEL), 8'(NUM_CTR)};
      REG_INFO_COND: rd_next = {24'b0, 8'(NUM_COND)};
      default:       rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // R5: strobe bit and reserved control bits read as zero
  a_r5_ctrl_low_zero: assert property (@(posedge clk) disable iff (rst)
    (addr == REG_CTRL) |=> rd_data[15:1] == '0);
  // R9: stray selection reads back zero
  a_r9_stray_read_zero: assert property (@(posedge clk) disable iff (rst)
    (!sel_ok && (addr == REG_COND || addr == REG_LOAD_LO || addr == REG_LOAD_HI))
    |=> rd_data == '0);
  // R10: unmapped addresses read zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (addr > REG_INFO_COND) |=> rd_data == '0);
  // R5: run bit follows a control write
  a_r5_run_follows: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_CTRL) |=> run_q == $past(wr_data[0]));
endmodule

// File: tb/perf_counter_bank_test.sv
module perf_counter_bank_test;
  localparam int NC = 4;
  localparam int WS = 1;
  localparam int NCOND = 8;
  localparam logic [47:0] MASK = 48'hFFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cond_in = '0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  perf_counter_bank #(.NUM_CTR(NC), .WIDTH_SEL(WS), .NUM_COND(NCOND)) uut (
    .clk(clk), .rst(rst), .cond_in(cond_in), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the register file
  logic [47:0] m_cnt [NC];
  logic [7:0]  m_cfg [NC];
  logic        m_run;
  logic [15:0] m_hi;
  logic [7:0]  m_sel;
  logic [31:0] m_cap_lo, m_cap_hi;
  logic [7:0]  cond_v = '0;
  logic [31:0] exp_rd;

  function automatic logic [31:0] model_read(input logic [3:0] a);
    logic ok = m_sel < NC;
    case (a)
      4'd0: return {m_hi, 15'b0, m_run};
      4'd1: return {24'b0, m_sel};
      4'd2: return ok ? {24'b0, m_cfg[m_sel[1:0]]} : 32'b0;
      4'd3: return ok ? m_cnt[m_sel[1:0]][31:0] : 32'b0;
      4'd4: return ok ? {16'b0, m_cnt[m_sel[1:0]][47:32]} : 32'b0;
      4'd5: return m_cap_lo;
      4'd6: return m_cap_hi;
      4'd7: return {20'b0, 4'(WS), 8'(NC)};
      4'd8: return 32'(NCOND);
      default: return 32'b0;
    endcase
  endfunction

  task automatic model_update(input logic [3:0] a, input logic w,
                              input logic [31:0] d, input logic [7:0] c);
    logic [47:0] pre [NC];
    logic ok = m_sel < NC;
    for (int i = 0; i < NC; i++) pre[i] = m_cnt[i];
    for (int i = 0; i < NC; i++) begin
      logic mine = w && ok && m_sel == 8'(i);
      logic inc = m_run && m_cfg[i] != 0 && m_cfg[i] < NCOND && c[m_cfg[i][2:0]];
      if (mine && a == 4'd3)      m_cnt[i] = {pre[i][47:32], d};
      else if (mine && a == 4'd4) m_cnt[i] = {d[15:0], pre[i][31:0]};
      else if (inc)               m_cnt[i] = (pre[i] + 48'd1) & MASK;
      if (mine && a == 4'd2) m_cfg[i] = d[7:0];
    end
    if (w && a == 4'd0) begin
      if (d[1] && ok) begin
        m_cap_lo = pre[m_sel[1:0]][31:0];
        m_cap_hi = {16'b0, pre[m_sel[1:0]][47:32]};
      end
      m_run = d[0];
      m_hi  = d[31:16];
    end
    if (w && a == 4'd1) m_sel = d[7:0];
  endtask

  task automatic step(input logic [3:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_en = w; wr_data = d; cond_in = cond_v;
    exp_rd = model_read(a);
    model_update(a, w, d, cond_v);
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    step(a, 1'b0, 32'b0);
    chk(tag, rd_data, exp_rd);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(a, 1'b1, d);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NC; i++) begin m_cnt[i] = '0; m_cfg[i] = '0; end
    m_run = 0; m_hi = '0; m_sel = '0; m_cap_lo = '0; m_cap_hi = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rd_data in reset", rd_data, 32'b0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;

    // R1 reset state, R8 build words, R10 unmapped
    for (int a = 0; a < 7; a++) rd(4'(a), "R1 reset register");
    rd(4'd7, "R8 counter info");
    rd(4'd8, "R8 condition info");
    wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd7, "R8 info write ignored");
    rd(4'd12, "R10 unmapped address");

    // R2 selection
    wr(4'd1, 32'h0000_0002);
    rd(4'd1, "R2 selection readback");

    // R3/R4 counting on condition 3 with all events high
    cond_v = 8'hFF;
    wr(4'd2, 32'd3);
    rd(4'd2, "R3 condition readback");
    wr(4'd0, 32'h0000_0001);
    repeat (5) step(4'd0, 1'b0, 32'b0);
    rd(4'd3, "R4 counting low half");
    cond_v = 8'h00;
    repeat (3) step(4'd0, 1'b0, 32'b0);
    rd(4'd3, "R4 no event no count");
    cond_v = 8'hFF;
    wr(4'd2, 32'd0);
    repeat (3) step(4'd0, 1'b0, 32'b0);
    rd(4'd3, "R3 condition zero holds");
    wr(4'd2, 32'd9);
    repeat (3) step(4'd0, 1'b0, 32'b0);
    rd(4'd3, "R3 out of range condition holds");

    // R5 run bit and upper control field
    wr(4'd2, 32'd5);
    wr(4'd0, 32'hABCD_0000);
    repeat (4) step(4'd0, 1'b0, 32'b0);
    rd(4'd3, "R5 stopped bank holds");
    rd(4'd0, "R5 control readback");

    // R7 load, R4 wrap across 48 bits
    wr(4'd3, 32'hFFFF_FFFE);
    wr(4'd4, 32'h0000_FFFF);
    rd(4'd4, "R7 high load");
    rd(4'd3, "R7 low load");
    wr(4'd0, 32'h0000_0001);
    wr(4'd3, 32'hFFFF_FFFD);
    rd(4'd3, "R7 load beats count");
    repeat (3) step(4'd0, 1'b0, 32'b0);
    rd(4'd4, "R4 wrap high half");
    rd(4'd3, "R4 wrap low half");

    // R6 capture then keep counting
    wr(4'd0, 32'h0000_0003);
    repeat (4) step(4'd0, 1'b0, 32'b0);
    rd(4'd5, "R6 capture low stable");
    rd(4'd6, "R6 capture high stable");
    rd(4'd0, "R6 strobe reads zero");

    // R9 stray selection
    wr(4'd1, 32'h0000_0007);
    wr(4'd2, 32'd4);
    wr(4'd3, 32'h1234_5678);
    wr(4'd0, 32'h0000_0003);
    rd(4'd2, "R9 stray condition read");
    rd(4'd3, "R9 stray count read");
    rd(4'd5, "R9 stray strobe ignored");
    wr(4'd1, 32'h0000_0002);
    rd(4'd2, "R9 real condition untouched");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 6);
      cond_v = 8'($urandom);
      case (op)
        0: wr(4'd1, 32'($urandom_range(0, 5)));
        1: wr(4'd2, 32'($urandom_range(0, 9)));
        2: wr(4'd0, $urandom & 32'hFFFF_0003);
        3: wr(4'd3, $urandom);
        4: wr(4'd4, $urandom);
        default: rd(4'($urandom_range(0, 10)), "R4 R6 R7 R9 random traffic");
      endcase
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule